// File: doc/BRIEF.md
# Transmit Pause Timer and Scheduler

This block sits in front of an Ethernet transmitter and decides, cycle by cycle, which frame may start next. It keeps a countdown timer that a receive-side pause detector loads with the pause time taken from a received pause frame. While the timer holds a non-zero value, no queued normal frame is allowed to begin. The timer counts down by one on each slot-time tick, but only while the transmitter is idle or is sending a pause frame that this block started.

A host-set send-pause request bypasses both the timer and the frame queue. A pause frame then starts as soon as the transmitter is free, and the block pulses a clear strobe so the request bit can be dropped. The block does not serialize frames or build the pause frame contents. It only issues start permissions, and it exposes the current timer value.

Top module: `tx_pause_sched`

## Requirements
- R1: After reset the timer value reads 0, and no pause frame is in progress.
- R2: `grant_normal` is high in the same cycle exactly when `frame_ready` is 1, `tx_busy` is 0, `pause_req` is 0 and the timer reads 0. A non-zero timer blocks it.
- R3: With no load, a `slot_tick` while `tx_busy` is 0 and the timer is non-zero lowers the timer by one at the next clock edge.
- R4: While a normal frame is in progress (`tx_busy` 1 after a `grant_normal`), slot ticks leave the timer unchanged.
- R5: `start_pause` and `pause_req_clr` are high together, in the same cycle, exactly when `pause_req` is 1 and `tx_busy` is 0. A request made during a busy frame waits for the first cycle with `tx_busy` 0.
- R6: A non-zero timer does not hold back `start_pause`.
- R7: A pause frame is in progress from the cycle after `start_pause` until the first cycle with `tx_busy` 0. During that time, slot ticks keep lowering the timer by one.
- R8: A `tmr_load` strobe writes `tmr_load_val` into the timer at the next edge. A load of 0 lets `grant_normal` rise in the following cycle.
- R9: The timer stops at 0. A tick at 0 leaves it at 0.
- R10: When `tmr_load` and `slot_tick` occur in the same cycle, the loaded value is stored and no decrement is applied.
- R11: When a pause request and a ready normal frame are both waiting on an idle transmitter, only `start_pause` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_load | input | 1 | Load strobe from the pause detector |
| tmr_load_val | input | 16 | Pause time to load |
| pause_req | input | 1 | Host send-pause request bit |
| slot_tick | input | 1 | One-cycle pulse per slot time |
| tx_busy | input | 1 | Transmitter is sending a frame |
| frame_ready | input | 1 | A normal frame is queued |
| grant_normal | output | 1 | Permission to start the queued frame |
| start_pause | output | 1 | Request to start a pause frame |
| pause_req_clr | output | 1 | Strobe to clear the send-pause bit |
| tmr_value | output | 16 | Current timer value |

## Verification
The start outputs (`grant_normal`, `start_pause`, `pause_req_clr`) are combinational from the current inputs and the registered state, so they are due in the same cycle as the stimulus. The timer value and the pause-in-progress state pass through one register, so a load or tick shows on `tmr_value` one edge later. The bench drives inputs just after a falling edge and compares all four results a moment later, against a reference model that it advances at the same rate. That way every comparison falls in the cycle where its result is due.

// File: rtl/tps_pkg.sv
package tps_pkg;
    // kind of frame currently on the wire, as seen by the scheduler
    typedef enum logic [1:0] {
        TXK_IDLE   = 2'd0,
        TXK_NORMAL = 2'd1,
        TXK_PAUSE  = 2'd2
    } tx_kind_e;
endpackage

// File: rtl/tps_pause_timer.sv
module tps_pause_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             tick,
    input  logic             dec_ok,
    output logic [TMR_W-1:0] cnt,
    output logic             cnt_zero
);
    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick && dec_ok && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt      = st_q.cnt;
    assign cnt_zero = (st_q.cnt == '0);

    // R8 / R10: a load always lands, ticks notwithstanding
    p_load_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));

    // R9: no wrap below zero
    p_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> cnt == '0);

    // R4: frozen while a normal frame occupies the wire
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec_ok) |=> $stable(cnt));
endmodule

// File: rtl/tps_start_arb.sv
module tps_start_arb
    import tps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_zero,
    input  logic pause_req,
    input  logic tx_busy,
    input  logic frame_ready,
    output logic grant,
    output logic start_pause,
    output logic req_clr,
    output logic dec_ok
);
    typedef struct packed {
        tx_kind_e kind;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic       idle;

    always_comb begin
        idle        = !tx_busy;
        // locally requested pause frame ignores the timer and the queue
        start_pause = idle && pause_req;
        grant       = idle && !pause_req && frame_ready && cnt_zero;
        req_clr     = start_pause;

        st_d = st_q;
        if (start_pause) begin
            st_d.kind = TXK_PAUSE;
        end else if (grant) begin
            st_d.kind = TXK_NORMAL;
        end else if (idle) begin
            st_d.kind = TXK_IDLE;
        end

        // count down when the wire is free or carries our own pause frame
        dec_ok = idle || (st_q.kind == TXK_PAUSE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.kind <= TXK_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // R11: never two starts in one cycle
    p_single_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && start_pause));

    // R7: a started pause frame keeps the timer live on the next busy cycle
    p_pause_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pause |=> dec_ok);

    // R5: nothing starts over a busy transmitter
    p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !(grant || start_pause));
endmodule

// File: rtl/tx_pause_sched.sv
module tx_pause_sched #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_load,
    input  logic [TMR_W-1:0] tmr_load_val,
    input  logic             pause_req,
    input  logic             slot_tick,
    input  logic             tx_busy,
    input  logic             frame_ready,
    output logic             grant_normal,
    output logic             start_pause,
    output logic             pause_req_clr,
    output logic [TMR_W-1:0] tmr_value
);
    logic cnt_zero;
    logic dec_ok;

    tps_pause_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_load_val),
        .tick     (slot_tick),
        .dec_ok   (dec_ok),
        .cnt      (tmr_value),
        .cnt_zero (cnt_zero)
    );

    tps_start_arb u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_zero    (cnt_zero),
        .pause_req   (pause_req),
        .tx_busy     (tx_busy),
        .frame_ready (frame_ready),
        .grant       (grant_normal),
        .start_pause (start_pause),
        .req_clr     (pause_req_clr),
        .dec_ok      (dec_ok)
    );

    // R2: a running timer holds back queued frames
    p_timer_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_value != '0) |-> !grant_normal);

    // R6: a pause request on an idle wire starts regardless of the timer
    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && !tx_busy) |-> start_pause);

    // R3: idle tick steps the timer down by exactly one
    p_idle_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_load && slot_tick && !tx_busy && tmr_value != '0)
        |=> tmr_value == $past(tmr_value) - 16'd1);

    // R1: timer empty out of reset
    p_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> tmr_value == '0);
endmodule

// File: tb/tx_pause_sched_tb_top.sv
module tx_pause_sched_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tmr_load;
    logic [15:0] tmr_load_val;
    logic        pause_req;
    logic        slot_tick;
    logic        tx_busy;
    logic        frame_ready;
    logic        grant_normal;
    logic        start_pause;
    logic        pause_req_clr;
    logic [15:0] tmr_value;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    logic [15:0] m_cnt;
    logic        m_ptx;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_pause_sched dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tmr_load      (tmr_load),
        .tmr_load_val  (tmr_load_val),
        .pause_req     (pause_req),
        .slot_tick     (slot_tick),
        .tx_busy       (tx_busy),
        .frame_ready   (frame_ready),
        .grant_normal  (grant_normal),
        .start_pause   (start_pause),
        .pause_req_clr (pause_req_clr),
        .tmr_value     (tmr_value)
    );

    function automatic logic f_grant(logic fr, logic busy, logic preq, logic [15:0] c);
        return fr && !busy && !preq && (c == 16'd0);
    endfunction

    function automatic logic f_pstart(logic busy, logic preq);
        return preq && !busy;
    endfunction

    function automatic logic [15:0] f_next_cnt(logic ld, logic [15:0] v, logic tk,
                                               logic busy, logic ptx, logic [15:0] c);
        if (ld) return v;
        if (tk && (!busy || ptx) && c != 16'd0) return c - 16'd1;
        return c;
    endfunction

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // one cycle: drive, check outputs, advance model
    task automatic step(logic ld, logic [15:0] v, logic preq, logic tk,
                        logic busy, logic fr, string tag);
        logic eg, es;
        @(negedge clk);
        tmr_load = ld; tmr_load_val = v; pause_req = preq;
        slot_tick = tk; tx_busy = busy; frame_ready = fr;
        #1;
        eg = f_grant(fr, busy, preq, m_cnt);
        es = f_pstart(busy, preq);
        chk(tag, "tmr_value", tmr_value, m_cnt);
        chk(tag, "grant_normal", 16'(grant_normal), 16'(eg));
        chk(tag, "start_pause", 16'(start_pause), 16'(es));
        chk(tag, "pause_req_clr", 16'(pause_req_clr), 16'(es));
        m_cnt = f_next_cnt(ld, v, tk, busy, m_ptx, m_cnt);
        m_ptx = es ? 1'b1 : (eg ? 1'b0 : (busy ? m_ptx : 1'b0));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int busy_left;
        logic preq_bit;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; tmr_load = 0; tmr_load_val = 0; pause_req = 0;
        slot_tick = 0; tx_busy = 0; frame_ready = 0;
        m_cnt = 0; m_ptx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        step(0, 0, 0, 0, 0, 0, "R1");
        // R8: load 3, then R2 blocked
        step(1, 16'd3, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 1, "R2");
        // R6: pause frame despite running timer, busy 2 cycles, R7 ticks count
        step(0, 0, 1, 0, 0, 1, "R6");
        step(0, 0, 0, 1, 1, 1, "R7");
        step(0, 0, 0, 0, 1, 1, "R7");
        // R3: idle tick
        step(0, 0, 0, 1, 0, 0, "R3");
        // R10: load wins over tick
        step(1, 16'd5, 0, 1, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, "R10");
        // R8: load zero releases next cycle
        step(1, 16'd0, 0, 0, 0, 1, "R8");
        step(0, 0, 0, 0, 0, 1, "R8");
        // R4: normal frame in flight freezes timer
        step(1, 16'd2, 0, 0, 1, 0, "R4");
        step(0, 0, 0, 1, 1, 0, "R4");
        step(0, 0, 0, 1, 1, 0, "R4");
        // R3/R9: count down through zero
        step(0, 0, 0, 1, 0, 0, "R3");
        step(0, 0, 0, 1, 0, 0, "R3");
        step(0, 0, 0, 1, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, "R9");
        // R5: request during busy waits, R11 priority over ready frame
        step(0, 0, 1, 0, 1, 1, "R5");
        step(0, 0, 1, 0, 0, 1, "R11");
        step(0, 0, 0, 0, 0, 1, "R2");

        // random phase with a simple transmitter and host model
        busy_left = 0;
        preq_bit  = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            logic ld, tk, fr, bz;
            logic [15:0] v;
            logic was_start;
            ld = ($urandom_range(0, 19) == 0);
            v  = ($urandom_range(0, 9) == 0) ? 16'hFFFF : 16'($urandom_range(0, 12));
            tk = ($urandom_range(0, 2) == 0);
            fr = ($urandom_range(0, 1) == 0);
            if (!preq_bit && $urandom_range(0, 24) == 0) preq_bit = 1'b1;
            bz = (busy_left > 0);
            was_start = !bz && (preq_bit || f_grant(fr, bz, preq_bit, m_cnt));
            step(ld, v, preq_bit, tk, bz, fr, "R2 R5 R7 random");
            if (busy_left > 0) busy_left--;
            if (was_start) busy_left = $urandom_range(1, 6);
            if (pause_req_clr) preq_bit = 1'b0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule